// File: doc/BRIEF.md
# Prioritized Conversion Queue Arbiter

This block shares a single data converter among several command queues. Each queue has a trigger source that software or hardware can drive, selected per queue. A trigger arms the queue. An armed queue offers its head command: a channel number plus an end-of-group flag. The arbiter sends one command at a time to the converter over a start/done handshake. When several armed queues have a command ready, the queue with the lowest index wins. A command leaves its queue only when its conversion completes. A queue disarms after it completes a command that carries the end-of-group flag.

Queue 0 is the urgent queue. Its trigger bypasses ordinary arbitration and aborts a conversion that is in flight. Its first command then starts exactly two cycles after the trigger. Queue 0 can also stream. Its group is kept in a small local buffer and replayed a programmed number of extra times, without being taken from the source again.

A command group is meant to run back to back. If a group is split, the arbiter raises a per-queue coherency interrupt. A split happens when another queue's command starts between two commands of the group, or when one of the group's commands is aborted.

Top module: `conv_queue_arb`

## Requirements
- R1: During and after synchronous reset (rst_n low), conv_start, conv_abort, cmd_ready and coh_irq are all 0 and no queue is armed. Commands marked valid are never started without a trigger.
- R2: When trig_sel[q] is 1, queue q is armed by a rising edge on hw_trig[q] and sw_trig[q] is ignored. When trig_sel[q] is 0, a high cycle on sw_trig[q] arms the queue and hw_trig[q] is ignored. Holding hw_trig high arms the queue only once.
- R3: When several armed queues have cmd_valid set and the converter is free, the queue with the lowest index is started first. conv_qid carries the queue index and conv_chan carries bits [q*CH_W +: CH_W] of cmd_chan.
- R4: conv_start is a one-cycle pulse. No new start is issued while a conversion is in flight, that is, until conv_done or conv_abort.
- R5: cmd_ready[q] is high only in a cycle where conv_done completes a command taken from queue q. At most one bit is high at a time. Queue 0 replays do not assert it.
- R6: A queue disarms after completing a command whose cmd_eog bit is 1, and it issues nothing more until it is triggered again.
- R7: If a queue 0 trigger is sampled in cycle c, conv_abort is high in cycle c+1 when a conversion is in flight. conv_start is high in cycle c+2 with conv_qid = 0, given that cmd_valid[0] is set.
- R8: An aborted command is not removed from its queue. It is issued again, with the same channel, when that queue next wins arbitration.
- R9: coh_irq[q] pulses for one cycle the first time queue q's group is split. A split is either an abort of one of its commands, or a start from another queue after some but not all of its commands have completed. It does not pulse again for that group.
- R10: With q0_repeat = N, queue 0's triggered group runs N+1 times in total. A count of 0 means the group runs once. cmd_ready[0] pulses only for the first pass.
- R11: A trigger on a queue that is already armed has no effect. For queue 0 this means no abort and no restart.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| trig_sel | input | NQ | Per-queue trigger source: 1 selects the hardware trigger, 0 selects software |
| sw_trig | input | NQ | Software trigger, one bit per queue, active high |
| hw_trig | input | NQ | Hardware trigger, one bit per queue, rising-edge sensitive |
| q0_repeat | input | RPT_W | Number of extra passes for the queue 0 group |
| cmd_valid | input | NQ | Head command present, one bit per queue |
| cmd_chan | input | NQ*CH_W | Head channel per queue; queue q occupies [q*CH_W +: CH_W] |
| cmd_eog | input | NQ | Head command ends its group |
| cmd_ready | output | NQ | Head command consumed (pulse on completion) |
| conv_start | output | 1 | Start a conversion (one-cycle pulse) |
| conv_abort | output | 1 | Abort the conversion in flight (one-cycle pulse) |
| conv_chan | output | CH_W | Channel of the started conversion |
| conv_qid | output | QW | Queue that owns the started conversion |
| conv_done | input | 1 | Converter finished the conversion in flight |
| coh_irq | output | NQ | Coherency-loss interrupt pulse per queue |

## Verification
A wrong arbitration state shows up at the start port. A wrong grant order, a stale armed flag or a missed disarm changes the sequence of conv_qid and conv_chan values at the very next start, within a few cycles of the conversion that ends. A pre-empt path that is out of step moves conv_abort or conv_start off the fixed two-cycle slot after the trigger, so the error is visible within three cycles. Wrong group or replay bookkeeping shows up later, at the end of a group. It appears as an extra or a missing start, a channel that breaks the replay order, a pop count that differs from the number of source commands, or a coherency pulse that is missing or repeated.

// File: rtl/cqa_pkg.sv
// Shared types for the conversion queue arbiter.
package cqa_pkg;
    // Arbiter sequencing states
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,   // converter free, choosing a queue
        ST_BUSY = 2'd1,   // conversion in flight
        ST_PRE  = 2'd2    // urgent queue pre-empt slot
    } arb_state_e;
endpackage

// File: rtl/cqa_trig.sv
// Trigger front end: selects per queue between a software pulse and a
// rising edge of a hardware trigger line.
// Assumes hw_trig is already synchronous to clk.
module cqa_trig #(
    parameter int NQ = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [NQ-1:0] trig_sel,
    input  logic [NQ-1:0] sw_trig,
    input  logic [NQ-1:0] hw_trig,
    output logic [NQ-1:0] arm_pulse
);
    logic [NQ-1:0] hw_prev;

    // Remember last hardware level for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) hw_prev <= '0;
        else        hw_prev <= hw_trig;
    end

    // Per-queue source selection
    generate
        for (genvar g = 0; g < NQ; g++) begin : g_sel
            assign arm_pulse[g] = trig_sel[g] ? (hw_trig[g] & ~hw_prev[g])
                                              : sw_trig[g];
        end
    endgenerate
endmodule

// File: rtl/cqa_prio.sv
// Fixed-priority picker: lowest requesting index wins.
// Assumes NQ >= 2.
module cqa_prio #(
    parameter int NQ = 4,
    parameter int QW = $clog2(NQ)
) (
    input  logic [NQ-1:0] req,
    output logic          any,
    output logic [QW-1:0] idx
);
    // Scan from the top so the lowest index is assigned last
    always_comb begin
        any = |req;
        idx = '0;
        for (int i = NQ - 1; i >= 0; i--) begin
            if (req[i]) idx = QW'(i);
        end
    end
endmodule

// File: rtl/cqa_stream.sv
// Streaming replay for the urgent queue: captures the channels of the
// first pass of a group and replays them for the remaining passes.
// Assumes a group holds at most GRP_MAX commands; any excess is not kept.
module cqa_stream #(
    parameter int CH_W    = 6,
    parameter int RPT_W   = 8,
    parameter int GRP_MAX = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [RPT_W-1:0] rpt_in,
    input  logic             done,
    input  logic [CH_W-1:0]  done_chan,
    input  logic             done_eog,
    output logic             rp_mode,
    output logic [CH_W-1:0]  rp_chan,
    output logic             rp_eog,
    output logic             last_pass
);
    localparam int AW = $clog2(GRP_MAX);
    localparam int CW = AW + 1;

    logic [CH_W-1:0]  grp_buf [GRP_MAX];
    logic [CW-1:0]    wr_cnt;
    logic [CW-1:0]    grp_len;
    logic [AW-1:0]    rp_idx;
    logic [RPT_W-1:0] passes;
    logic             room;

    assign room = wr_cnt < CW'(GRP_MAX);

    // Capture channels completed during the first pass
    always_ff @(posedge clk) begin
        if (done && !rp_mode && room) grp_buf[wr_cnt[AW-1:0]] <= done_chan;
    end

    // Pass counting and replay pointer
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rp_mode <= 1'b0;
            wr_cnt  <= '0;
            grp_len <= '0;
            rp_idx  <= '0;
            passes  <= '0;
        end else if (load) begin
            rp_mode <= 1'b0;
            wr_cnt  <= '0;
            rp_idx  <= '0;
            passes  <= rpt_in;
        end else if (done) begin
            if (!rp_mode && room) wr_cnt <= wr_cnt + 1'b1;
            if (done_eog) begin
                if (passes != '0) begin
                    passes  <= passes - 1'b1;
                    rp_mode <= 1'b1;
                    rp_idx  <= '0;
                    if (!rp_mode) grp_len <= room ? wr_cnt + 1'b1 : wr_cnt;
                end else begin
                    rp_mode <= 1'b0;
                    wr_cnt  <= '0;
                end
            end else if (rp_mode) begin
                rp_idx <= rp_idx + 1'b1;
            end
        end
    end

    assign rp_chan   = grp_buf[rp_idx];
    assign rp_eog    = ({1'b0, rp_idx} == grp_len - 1'b1);
    assign last_pass = (passes == '0);
endmodule

// File: rtl/conv_queue_arb.sv
// Conversion queue arbiter: grants one converter to NQ command queues by
// fixed priority. Queue 0 pre-empts with a fixed two-cycle start latency
// and may stream. Group splits raise a per-queue coherency interrupt.
// Assumes sources hold their head command until cmd_ready, and that
// cmd_valid[0] is set when queue 0 is triggered.
module conv_queue_arb
    import cqa_pkg::*;
#(
    parameter int NQ      = 4,
    parameter int CH_W    = 6,
    parameter int RPT_W   = 8,
    parameter int GRP_MAX = 8,
    localparam int QW     = $clog2(NQ)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NQ-1:0]    trig_sel,
    input  logic [NQ-1:0]    sw_trig,
    input  logic [NQ-1:0]    hw_trig,
    input  logic [RPT_W-1:0] q0_repeat,
    input  logic [NQ-1:0]    cmd_valid,
    input  logic [NQ*CH_W-1:0] cmd_chan,
    input  logic [NQ-1:0]    cmd_eog,
    output logic [NQ-1:0]    cmd_ready,
    output logic             conv_start,
    output logic             conv_abort,
    output logic [CH_W-1:0]  conv_chan,
    output logic [QW-1:0]    conv_qid,
    input  logic             conv_done,
    output logic [NQ-1:0]    coh_irq
);
    arb_state_e      state;
    logic [NQ-1:0]   arm_pulse, armed, req, mid, brk, fin_grp, brk_evt;
    logic [CH_W-1:0] src_chan [NQ];
    logic [NQ-1:0]   src_eog;
    logic [QW-1:0]   cur_q, win, launch_q;
    logic            cur_eog, cur_rep, any_req;
    logic            trig0, done_now, launch, abort_evt;
    logic            rp_mode, rp_eog, last_pass;
    logic [CH_W-1:0] rp_chan;

    cqa_trig #(.NQ(NQ)) u_trig (
        .clk(clk), .rst_n(rst_n), .trig_sel(trig_sel),
        .sw_trig(sw_trig), .hw_trig(hw_trig), .arm_pulse(arm_pulse)
    );

    cqa_prio #(.NQ(NQ), .QW(QW)) u_prio (
        .req(req), .any(any_req), .idx(win)
    );

    cqa_stream #(.CH_W(CH_W), .RPT_W(RPT_W), .GRP_MAX(GRP_MAX)) u_stream (
        .clk(clk), .rst_n(rst_n), .load(trig0), .rpt_in(q0_repeat),
        .done(done_now && cur_q == '0), .done_chan(conv_chan),
        .done_eog(cur_eog), .rp_mode(rp_mode), .rp_chan(rp_chan),
        .rp_eog(rp_eog), .last_pass(last_pass)
    );

    assign trig0     = arm_pulse[0] & ~armed[0];
    assign done_now  = (state == ST_BUSY) && conv_done;
    assign abort_evt = (state == ST_BUSY) && trig0 && !conv_done;
    assign launch    = ((state == ST_IDLE) && !trig0 && any_req)
                     || ((state == ST_PRE) && req[0]);
    assign launch_q  = (state == ST_PRE) ? '0 : win;

    // Per-queue command view, pop, group finish and split detection
    generate
        for (genvar g = 0; g < NQ; g++) begin : g_q
            if (g == 0) begin : g_urgent
                assign src_chan[g] = rp_mode ? rp_chan : cmd_chan[CH_W-1:0];
                assign src_eog[g]  = rp_mode ? rp_eog : cmd_eog[0];
                assign req[g]      = armed[0] & (rp_mode | cmd_valid[0]);
                assign fin_grp[g]  = done_now && cur_q == '0 && cur_eog && last_pass;
            end else begin : g_norm
                assign src_chan[g] = cmd_chan[g*CH_W +: CH_W];
                assign src_eog[g]  = cmd_eog[g];
                assign req[g]      = armed[g] & cmd_valid[g];
                assign fin_grp[g]  = done_now && cur_q == QW'(g) && cur_eog;
            end
            assign cmd_ready[g] = done_now && cur_q == QW'(g) && !cur_rep;
            assign brk_evt[g]   = (launch && launch_q != QW'(g) && mid[g])
                                || (abort_evt && cur_q == QW'(g));
        end
    endgenerate

    // Arm on an accepted trigger, disarm on the last group completion
    always_ff @(posedge clk) begin
        if (!rst_n) armed <= '0;
        else        armed <= (armed & ~fin_grp) | (arm_pulse & ~armed);
    end

    // Sequencer: launch, wait for done, pre-empt for queue 0
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state      <= ST_IDLE;
            conv_start <= 1'b0;
            conv_abort <= 1'b0;
            conv_chan  <= '0;
            conv_qid   <= '0;
            cur_q      <= '0;
            cur_eog    <= 1'b0;
            cur_rep    <= 1'b0;
        end else begin
            conv_start <= 1'b0;
            conv_abort <= 1'b0;
            if (launch) begin
                conv_start <= 1'b1;
                conv_qid   <= launch_q;
                conv_chan  <= src_chan[launch_q];
                cur_q      <= launch_q;
                cur_eog    <= src_eog[launch_q];
                cur_rep    <= (launch_q == '0) && rp_mode;
                state      <= ST_BUSY;
            end else begin
                case (state)
                    ST_IDLE: if (trig0) state <= ST_PRE;
                    ST_BUSY: begin
                        if (trig0) begin
                            conv_abort <= !conv_done;
                            state      <= ST_PRE;
                        end else if (conv_done) begin
                            state <= ST_IDLE;
                        end
                    end
                    default: state <= ST_IDLE;
                endcase
            end
        end
    end

    // Group coherency tracking and interrupt pulses
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mid     <= '0;
            brk     <= '0;
            coh_irq <= '0;
        end else begin
            for (int q = 0; q < NQ; q++) begin
                if (done_now && cur_q == QW'(q)) begin
                    mid[q] <= !cur_eog;
                    if (cur_eog) brk[q] <= 1'b0;
                end
                if (brk_evt[q]) brk[q] <= 1'b1;
                coh_irq[q] <= brk_evt[q] & ~brk[q];
            end
        end
    end
endmodule

// File: rtl/conv_queue_arb_chk.sv
// Port-level protocol checker for the conversion queue arbiter.
// It keeps its own in-flight flag, rebuilt from start, done and abort.
module conv_queue_arb_chk #(
    parameter int NQ = 4,
    parameter int QW = 2
) (
    input logic          clk,
    input logic          rst_n,
    input logic          conv_start,
    input logic          conv_abort,
    input logic          conv_done,
    input logic [QW-1:0] conv_qid,
    input logic [NQ-1:0] cmd_ready,
    input logic [NQ-1:0] coh_irq
);
    logic in_flight;

    // Track whether the converter holds an open conversion
    always_ff @(posedge clk) begin
        if (!rst_n)                       in_flight <= 1'b0;
        else if (conv_start)              in_flight <= 1'b1;
        else if (conv_done || conv_abort) in_flight <= 1'b0;
    end

    AST_START_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        conv_start |=> !conv_start);                                  // R4
    AST_NO_START_IN_FLIGHT: assert property (@(posedge clk) disable iff (!rst_n)
        conv_start |-> !in_flight);                                   // R4
    AST_ABORT_IN_FLIGHT: assert property (@(posedge clk) disable iff (!rst_n)
        conv_abort |-> in_flight);                                    // R7
    AST_ABORT_THEN_URGENT: assert property (@(posedge clk) disable iff (!rst_n)
        conv_abort |=> (conv_start && conv_qid == '0));               // R7
    AST_POP_ON_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        (|cmd_ready) |-> conv_done);                                  // R5
    AST_POP_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(cmd_ready));                                         // R5
    AST_IRQ_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        (|coh_irq) |=> ((coh_irq & $past(coh_irq)) == '0));           // R9
endmodule

bind conv_queue_arb conv_queue_arb_chk #(.NQ(NQ), .QW(QW)) u_chk (
    .clk(clk), .rst_n(rst_n), .conv_start(conv_start),
    .conv_abort(conv_abort), .conv_done(conv_done), .conv_qid(conv_qid),
    .cmd_ready(cmd_ready), .coh_irq(coh_irq)
);

// File: tb/tb_conv_queue_arb.sv
// Bench for conv_queue_arb: a priority vector table, then directed cases.
module tb_conv_queue_arb;
    localparam int NQ = 4;
    localparam int CH = 6;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NQ-1:0] trig_sel = '0, sw_trig = '0, hw_trig = '0;
    logic [7:0]    q0_repeat = '0;
    logic [NQ-1:0] cmd_valid, cmd_eog, cmd_ready, coh_irq;
    logic [NQ*CH-1:0] cmd_chan;
    logic          conv_start, conv_abort, conv_done;
    logic [CH-1:0] conv_chan;
    logic [1:0]    conv_qid;

    conv_queue_arb dut (
        .clk(clk), .rst_n(rst_n), .trig_sel(trig_sel), .sw_trig(sw_trig),
        .hw_trig(hw_trig), .q0_repeat(q0_repeat), .cmd_valid(cmd_valid),
        .cmd_chan(cmd_chan), .cmd_eog(cmd_eog), .cmd_ready(cmd_ready),
        .conv_start(conv_start), .conv_abort(conv_abort),
        .conv_chan(conv_chan), .conv_qid(conv_qid), .conv_done(conv_done),
        .coh_irq(coh_irq)
    );

    always #10 clk = ~clk;   // 50 MHz

    int n_chk = 0, n_err = 0, wd = 0;
    int cyc, n_start, n_abort, abort_cyc, t_trig, lat = 3;
    int log_q [64], log_ch [64], log_cyc [64];
    int idx [NQ], pops [NQ], irqs [NQ], grp_len [NQ];
    logic [NQ-1:0] src_en = '0;
    logic conv_busy;
    int   conv_cnt;

    // Command sources: queue q offers channel q*16+index
    always_comb begin
        cmd_valid = src_en;
        for (int q = 0; q < NQ; q++) begin
            cmd_chan[q*CH +: CH] = CH'((q * 16 + idx[q]) % 64);
            cmd_eog[q] = (idx[q] % grp_len[q]) == grp_len[q] - 1;
        end
    end

    // Monitor log plus a converter model with fixed latency
    always @(posedge clk) begin
        if (!rst_n) begin
            cyc <= 0; n_start <= 0; n_abort <= 0; abort_cyc <= -1;
            conv_busy <= 1'b0; conv_cnt <= 0; conv_done <= 1'b0;
            for (int q = 0; q < NQ; q++) begin
                idx[q] <= 0; pops[q] <= 0; irqs[q] <= 0;
            end
        end else begin
            cyc <= cyc + 1;
            if (conv_start && n_start < 64) begin
                log_q[n_start] <= int'(conv_qid);
                log_ch[n_start] <= int'(conv_chan);
                log_cyc[n_start] <= cyc;
                n_start <= n_start + 1;
            end
            if (conv_abort) begin
                abort_cyc <= cyc;
                n_abort <= n_abort + 1;
            end
            for (int q = 0; q < NQ; q++) begin
                if (cmd_ready[q]) begin
                    idx[q] <= idx[q] + 1;
                    pops[q] <= pops[q] + 1;
                end
                if (coh_irq[q]) irqs[q] <= irqs[q] + 1;
            end
            conv_done <= 1'b0;
            if (conv_abort) conv_busy <= 1'b0;
            else if (conv_start) begin
                conv_busy <= 1'b1;
                conv_cnt <= lat;
            end else if (conv_busy) begin
                if (conv_cnt <= 1) begin
                    conv_done <= 1'b1;
                    conv_busy <= 1'b0;
                end else conv_cnt <= conv_cnt - 1;
            end
        end
    end

    // Watchdog: a hung run counts as a failure and still reports
    always @(posedge clk) begin
        wd <= wd + 1;
        if (wd > 150000) begin
            n_err = n_err + 1;
            $display("FAIL watchdog actual=%0d expected=<150000", wd);
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    end

    task automatic chk(input string rq, input int act, input int exp);
        n_chk = n_chk + 1;
        if (act != exp) begin
            n_err = n_err + 1;
            $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
        end
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; sw_trig = '0; hw_trig = '0; trig_sel = '0;
        src_en = '0; q0_repeat = '0; lat = 3;
        for (int q = 0; q < NQ; q++) grp_len[q] = 1;
        wait_cyc(3);
        rst_n = 1'b1;
    endtask

    task automatic trig_sw(input logic [NQ-1:0] m);
        @(negedge clk) sw_trig = m;
        @(posedge clk) t_trig = cyc;
        @(negedge clk) sw_trig = '0;
    endtask

    // Vector: [15:12] trigger mask, [11:8] start count, then 2-bit queue ids
    localparam logic [15:0] VEC [6] = '{
        16'hE36C, 16'hC2B0, 16'hA270, 16'h4180, 16'h81C0, 16'h6260
    };

    initial begin
        for (int q = 0; q < NQ; q++) grp_len[q] = 1;
        do_reset();

        // R1: quiet outputs during and after reset, no arming without trigger
        @(negedge clk) rst_n = 1'b0;
        @(negedge clk);
        chk("R1 start in reset", int'(conv_start), 0);
        chk("R1 abort in reset", int'(conv_abort), 0);
        rst_n = 1'b1;
        src_en = 4'b1111;
        wait_cyc(10);
        chk("R1 no start untriggered", n_start, 0);
        chk("R1 ready idle", int'(cmd_ready), 0);
        chk("R1 irq idle", int'(coh_irq), 0);

        // R3 / R6: priority order table
        for (int v = 0; v < 6; v++) begin
            logic [15:0] vec;
            vec = VEC[v];
            do_reset();
            src_en = 4'b1110;
            trig_sw(vec[15:12]);
            wait_cyc(40);
            chk("R3 R6 start count", n_start, int'(vec[11:8]));
            for (int k = 0; k < int'(vec[11:8]); k++) begin
                chk("R3 grant order", log_q[k], int'(vec[7-2*k -: 2]));
                chk("R3 channel", log_ch[k], int'(vec[7-2*k -: 2]) * 16);
            end
        end

        // R2: trigger source selection
        do_reset();
        trig_sel = 4'b0100;
        src_en = 4'b1100;
        trig_sw(4'b0100);
        wait_cyc(10);
        chk("R2 sw ignored in hw mode", n_start, 0);
        @(negedge clk) hw_trig[2] = 1'b1;
        wait_cyc(3);
        hw_trig[2] = 1'b0;
        wait_cyc(20);
        chk("R2 hw edge arms once", n_start, 1);
        chk("R2 hw queue id", log_q[0], 2);
        @(negedge clk) hw_trig[3] = 1'b1;
        wait_cyc(2);
        hw_trig[3] = 1'b0;
        wait_cyc(20);
        chk("R2 hw ignored in sw mode", n_start, 1);

        // R6: three-command group then disarm
        do_reset();
        grp_len[1] = 3;
        src_en = 4'b0010;
        trig_sw(4'b0010);
        wait_cyc(60);
        chk("R6 group length", n_start, 3);
        chk("R6 last channel", log_ch[2], 18);
        chk("R5 pops", pops[1], 3);

        // R9 / R4 / R5: split by a higher queue between group commands
        do_reset();
        lat = 6;
        grp_len[3] = 2;
        src_en = 4'b1010;
        trig_sw(4'b1000);
        wait_cyc(2);
        trig_sw(4'b0010);
        wait_cyc(60);
        chk("R9 start count", n_start, 3);
        chk("R9 order first", log_q[0], 3);
        chk("R9 order second", log_q[1], 1);
        chk("R9 order third", log_ch[2], 49);
        chk("R9 irq split queue", irqs[3], 1);
        chk("R9 irq other queue", irqs[1], 0);
        chk("R4 gap exceeds latency", int'(log_cyc[1] - log_cyc[0] > lat), 1);
        chk("R5 pops q3", pops[3], 2);

        // R7 / R8 / R9: queue 0 pre-empts a running conversion
        do_reset();
        lat = 20;
        grp_len[2] = 2;
        src_en = 4'b0101;
        trig_sw(4'b0100);
        wait_cyc(5);
        trig_sw(4'b0001);
        wait_cyc(2);
        chk("R7 abort count", n_abort, 1);
        chk("R7 abort slot", abort_cyc, t_trig + 1);
        chk("R7 urgent queue", log_q[1], 0);
        chk("R7 start slot", log_cyc[1], t_trig + 2);
        wait_cyc(120);
        chk("R8 reissue queue", log_q[2], 2);
        chk("R8 reissue channel", log_ch[2], 32);
        chk("R8 group tail", log_ch[3], 33);
        chk("R8 pops q2", pops[2], 2);
        chk("R9 irq on abort", irqs[2], 1);

        // R10: streaming with two extra passes
        do_reset();
        lat = 2;
        grp_len[0] = 2;
        q0_repeat = 8'd2;
        src_en = 4'b0001;
        trig_sw(4'b0001);
        wait_cyc(80);
        chk("R10 total starts", n_start, 6);
        for (int k = 0; k < 6; k++) chk("R10 replay channel", log_ch[k], k % 2);
        chk("R10 pops first pass only", pops[0], 2);

        // R10: count 0 runs once
        do_reset();
        lat = 2;
        grp_len[0] = 2;
        src_en = 4'b0001;
        trig_sw(4'b0001);
        wait_cyc(40);
        chk("R10 zero count", n_start, 2);

        // R11: repeat trigger on armed queue 0
        do_reset();
        lat = 30;
        src_en = 4'b0001;
        trig_sw(4'b0001);
        wait_cyc(4);
        trig_sw(4'b0001);
        wait_cyc(60);
        chk("R11 no abort", n_abort, 0);
        chk("R11 single start", n_start, 1);
        chk("R11 single pop", pops[0], 1);

        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end
endmodule